// File: doc/BRIEF.md
# Seconds Counter with Alarm and Once-per-Second Tick

This block keeps a 32-bit count of seconds. A strobe input marks each edge of a 32.768 kHz reference. A prescaler with a divisor that software can change turns those strobes into counter steps, so software can trim the step rate away from exactly one per second. Two events are derived from the count:

- an alarm match against a programmable value;
- a tick on every step.

Each event has its own enable, its own sticky detected flag and its own interrupt line.

Software reaches the block through a simple word-wide register port. It can read and write the alarm value, the live count, the divisor and a status word. In the status word the enables are written directly and the detected flags are cleared by writing ones. Writing the count replaces it and restarts the prescaler, so the next step comes a full prescaler period after the write.

Top module: `secs_rtc`

## Requirements
- R1: After reset the alarm register (offset 0x00), the count (0x04) and the status word (0x10) read zero, the divisor (0x08) reads 32767, and both interrupt outputs are low.
- R2: The count rises by exactly one for every trim+1 strobes on `slow_tick`, where trim is the low 16 bits written at offset 0x08; the upper 16 bits of that register always read zero.
- R3: A write to offset 0x04 replaces the count and restarts the prescaler, so the next step needs a further trim+1 strobes; a strobe in the same cycle as that write produces no step.
- R4: Stepping from 0xFFFFFFFF gives a count of zero.
- R5: Status bit 1 (tick detected) is set by every step while status bit 3 (tick enable) is 1. It is not set while bit 3 is 0, and it is not set by a write to the count.
- R6: Status bit 0 (alarm detected) is set when status bit 2 (alarm enable) is 1 and the count becomes equal to the alarm value, through either a step or a write. It is not set while bit 2 is 0.
- R7: A write to offset 0x10 loads bits 2 and 3 from the data and clears bit 0 or bit 1 only where the data holds a 1 in that position. A detected flag otherwise stays set.
- R8: When a detected flag is cleared in the same cycle as a new event of its kind, the flag ends up set.
- R9: `irq_alarm` equals status bit 0 and `irq_tick` equals status bit 1 at all times.
- R10: Offsets other than 0x00, 0x04, 0x08 and 0x10 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per edge of the 32.768 kHz reference |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_alarm | output | 1 | Alarm interrupt, level |
| irq_tick | output | 1 | Tick interrupt, level |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a count write and a prescaler strobe. The bench provokes it by raising `slow_tick` in the very cycle that writes the count. It judges the result by reading back exactly the written value, then confirming that the next step comes only after a full divisor period.

The second pair is a software clear of the tick flag and a new step that would set it. The bench writes a one to that flag's position while a strobe produces a step. It expects the flag, and `irq_tick`, to read set afterwards.

Divisor sweeps over small trim values compute the expected count as the strobe count divided by trim+1.

// File: rtl/secs_rtc_pkg.sv
// Package: shared offsets, status bit positions and the status record
// for the seconds counter. Assumes byte offsets on a word-wide port.
package secs_rtc_pkg;

    localparam int OFS_ALARM = 'h00;
    localparam int OFS_COUNT = 'h04;
    localparam int OFS_TRIM  = 'h08;
    localparam int OFS_STAT  = 'h10;

    // Bit positions in the status word, decoded by software.
    localparam int ST_AL_DET = 0;
    localparam int ST_HZ_DET = 1;
    localparam int ST_AL_EN  = 2;
    localparam int ST_HZ_EN  = 3;
    localparam int ST_BITS   = 4;

    typedef struct packed {
        logic hz_en;
        logic al_en;
        logic hz_det;
        logic al_det;
    } rtc_stat_t;

endpackage

// File: rtl/rtc_prescaler.sv
// Module: divides the reference strobes by trim+1 and emits a one-cycle
// step. Assumes slow_tick is a single-cycle strobe. A restart request
// clears the phase and suppresses any step in that cycle. A divisor
// lowered below the current phase gives a step on the next strobe.
module rtc_prescaler #(
    parameter int TRIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              restart,
    input  logic [TRIM_W-1:0] trim,
    output logic              step,
    output logic [TRIM_W-1:0] phase_q
);

    logic at_end;

    // Period boundary reached on this strobe.
    always_comb begin
        at_end = (phase_q >= trim);
        step   = slow_tick && !restart && at_end;
    end

    // Phase counter: restart wins, else advance or wrap on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (slow_tick) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_seconds.sv
// Module: the seconds count. A software load replaces it, and a step
// adds one with natural wrap. It also reports whether the value about
// to be stored equals the alarm, and only on cycles where the count is
// loaded or stepped.
module rtc_seconds #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    input  logic [DATA_W-1:0] alarm_val,
    output logic [DATA_W-1:0] count_q,
    output logic              hit
);

    logic [DATA_W-1:0] count_nxt;

    // Next count and alarm comparison on the value being stored.
    always_comb begin
        count_nxt = count_q;
        if (load) begin
            count_nxt = load_val;
        end else if (step) begin
            count_nxt = count_q + 1'b1;
        end
        hit = (load || step) && (count_nxt == alarm_val);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_nxt;
        end
    end

endmodule

// File: rtl/rtc_events.sv
// Module: status word. The enables load from software writes. The
// detected flags are sticky, cleared by writing ones, and a new event
// in the same cycle as a clear wins. Events are gated by the enables
// held before the current write.
module rtc_events
    import secs_rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stat_wr,
    input  logic [ST_BITS-1:0] stat_wdata,
    input  logic               step,
    input  logic               hit,
    output rtc_stat_t          stat_q
);

    logic al_set;
    logic hz_set;
    logic al_clr;
    logic hz_clr;

    // Event and clear conditions for this cycle.
    always_comb begin
        al_set = stat_q.al_en && hit;
        hz_set = stat_q.hz_en && step;
        al_clr = stat_wr && stat_wdata[ST_AL_DET];
        hz_clr = stat_wr && stat_wdata[ST_HZ_DET];
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            if (stat_wr) begin
                stat_q.al_en <= stat_wdata[ST_AL_EN];
                stat_q.hz_en <= stat_wdata[ST_HZ_EN];
            end
            stat_q.al_det <= al_set || (stat_q.al_det && !al_clr);
            stat_q.hz_det <= hz_set || (stat_q.hz_det && !hz_clr);
        end
    end

endmodule

// File: rtl/rtc_regif.sv
// Module: register port. It decodes byte offsets into write strobes,
// holds the alarm and divisor registers, and returns read data for the
// presented offset. Offsets outside the map read zero and ignore writes.
module rtc_regif
    import secs_rtc_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter int              ADDR_W     = 5,
    parameter int              TRIM_W     = 16,
    parameter logic [TRIM_W-1:0] TRIM_RESET = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count_q,
    input  rtc_stat_t         stat_q,
    output logic              count_wr,
    output logic              stat_wr,
    output logic [DATA_W-1:0] alarm_q,
    output logic [TRIM_W-1:0] trim_q,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFS_ALARM);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_TRIM  = ADDR_W'(OFS_TRIM);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    logic alarm_wr;
    logic trim_wr;

    // Write strobe decode.
    always_comb begin
        alarm_wr = bus_wr && (bus_addr == A_ALARM);
        count_wr = bus_wr && (bus_addr == A_COUNT);
        trim_wr  = bus_wr && (bus_addr == A_TRIM);
        stat_wr  = bus_wr && (bus_addr == A_STAT);
    end

    // Alarm value and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            trim_q  <= TRIM_RESET;
        end else begin
            if (alarm_wr) begin
                alarm_q <= bus_wdata;
            end
            if (trim_wr) begin
                trim_q <= bus_wdata[TRIM_W-1:0];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        unique case (bus_addr)
            A_ALARM: bus_rdata = alarm_q;
            A_COUNT: bus_rdata = count_q;
            A_TRIM:  bus_rdata = DATA_W'(trim_q);
            A_STAT:  bus_rdata = DATA_W'(stat_q);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/secs_rtc.sv
// Module: top of the seconds counter. It joins the register port, the
// prescaler, the count and the status word. Everything runs on one
// clock. The 32.768 kHz reference must arrive as a synchronous strobe.
module secs_rtc #(
    parameter int              DATA_W     = 32,
    parameter int              ADDR_W     = 5,
    parameter int              TRIM_W     = 16,
    parameter logic [TRIM_W-1:0] TRIM_RESET = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_alarm,
    output logic              irq_tick
);
    import secs_rtc_pkg::*;

    logic              count_wr;
    logic              stat_wr;
    logic              step;
    logic              hit;
    logic [DATA_W-1:0] alarm_q;
    logic [DATA_W-1:0] count_q;
    logic [TRIM_W-1:0] trim_q;
    logic [TRIM_W-1:0] phase_q;
    rtc_stat_t         stat_q;

    rtc_regif #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TRIM_W(TRIM_W), .TRIM_RESET(TRIM_RESET)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count_q(count_q), .stat_q(stat_q),
        .count_wr(count_wr), .stat_wr(stat_wr), .alarm_q(alarm_q),
        .trim_q(trim_q), .bus_rdata(bus_rdata)
    );

    rtc_prescaler #(.TRIM_W(TRIM_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .restart(count_wr),
        .trim(trim_q), .step(step), .phase_q(phase_q)
    );

    rtc_seconds #(.DATA_W(DATA_W)) u_secs (
        .clk(clk), .rst_n(rst_n), .load(count_wr), .load_val(bus_wdata),
        .step(step), .alarm_val(alarm_q), .count_q(count_q), .hit(hit)
    );

    rtc_events u_events (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr),
        .stat_wdata(bus_wdata[ST_BITS-1:0]), .step(step), .hit(hit),
        .stat_q(stat_q)
    );

    // Interrupt lines follow the sticky detected flags.
    always_comb begin
        irq_alarm = stat_q.al_det;
        irq_tick  = stat_q.hz_det;
    end

endmodule

// File: rtl/secs_rtc_chk.sv
// Checker: temporal properties of the seconds counter. It is bound into
// the top module and observes ports and the count, phase and alarm state.
module secs_rtc_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int TRIM_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_alarm,
    input logic              irq_tick,
    input logic [DATA_W-1:0] count_q,
    input logic [TRIM_W-1:0] phase_q,
    input logic [DATA_W-1:0] alarm_q,
    input logic              al_en
);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(secs_rtc_pkg::OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(secs_rtc_pkg::OFS_STAT);

    logic cnt_wr;
    logic al_clear;
    assign cnt_wr   = bus_wr && (bus_addr == A_COUNT);
    assign al_clear = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

    a_r3_write_restarts_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr) |-> (phase_q == '0) && (count_q == $past(bus_wdata)));

    a_r2_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) && !$past(cnt_wr) |-> count_q == $past(count_q) + 1'b1);

    a_r6_alarm_rise_matches: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_alarm) |-> $past(al_en) && (count_q == $past(alarm_q)));

    a_r5_tick_rise_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tick) |-> !$past(cnt_wr) && (count_q == $past(count_q) + 1'b1));

    a_r7_alarm_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_alarm) |-> $past(al_clear));

    a_r9_irq_match_status: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> (bus_rdata[1:0] == {irq_tick, irq_alarm}));

endmodule

bind secs_rtc secs_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_alarm(irq_alarm),
    .irq_tick(irq_tick), .count_q(count_q), .phase_q(phase_q),
    .alarm_q(alarm_q), .al_en(stat_q.al_en)
);

// File: tb/secs_rtc_tb.sv
module secs_rtc_tb;

    localparam logic [4:0] A_AL = 5'h00;
    localparam logic [4:0] A_CN = 5'h04;
    localparam logic [4:0] A_TR = 5'h08;
    localparam logic [4:0] A_ST = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_alarm;
    logic        irq_tick;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    secs_rtc u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_alarm(irq_alarm), .irq_tick(irq_tick)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; slow_tick = tk;
        @(negedge clk);
        bus_wr = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_AL, v); chk("R1 alarm", v, 32'h0);
        rd(A_CN, v); chk("R1 count", v, 32'h0);
        rd(A_TR, v); chk("R1 trim", v, 32'd32767);
        rd(A_ST, v); chk("R1 status", v, 32'h0);
        chk("R1 irqs", {30'h0, irq_tick, irq_alarm}, 32'h0);

        // R2 divisor sweep: count = strobes / (trim+1)
        for (int t = 0; t < 4; t++) begin
            wr(A_TR, t, 1'b0);
            wr(A_CN, 0, 1'b0);
            for (int k = 1; k <= (t + 1) * 3; k++) begin
                pulse();
                rd(A_CN, v);
                chk($sformatf("R2 trim=%0d strobes=%0d", t, k), v, k / (t + 1));
            end
        end
        wr(A_TR, 32'hABCD_0002, 1'b0);
        rd(A_TR, v); chk("R2 trim upper bits", v, 32'h2);

        // R3 count write restarts phase (trim 3)
        wr(A_TR, 3, 1'b0);
        wr(A_CN, 0, 1'b0);
        pulse(); pulse();
        wr(A_CN, 100, 1'b0);
        pulse(); pulse(); pulse();
        rd(A_CN, v); chk("R3 no early step", v, 100);
        pulse();
        rd(A_CN, v); chk("R3 full period", v, 101);

        // R3 strobe in the same cycle as the write (trim 0)
        wr(A_TR, 0, 1'b0);
        wr(A_CN, 50, 1'b1);
        rd(A_CN, v); chk("R3 coincident strobe", v, 50);
        pulse();
        rd(A_CN, v); chk("R3 after coincident", v, 51);

        // R4 wrap
        wr(A_CN, 32'hFFFF_FFFF, 1'b0);
        pulse();
        rd(A_CN, v); chk("R4 wrap", v, 0);

        // R5 tick flag disabled
        pulse();
        rd(A_ST, v); chk("R5 disabled no flag", v, 32'h0);
        // R5 enabled
        wr(A_ST, 32'h8, 1'b0);
        pulse();
        rd(A_ST, v); chk("R5 flag set", v, 32'hA);
        chk("R9 irq_tick high", irq_tick, 1);
        // R7 writing zero keeps the flag
        wr(A_ST, 32'h8, 1'b0);
        rd(A_ST, v); chk("R7 zero keeps", v, 32'hA);
        // R7 one clears, enable kept
        wr(A_ST, 32'hA, 1'b0);
        rd(A_ST, v); chk("R7 clear hz", v, 32'h8);
        chk("R9 irq_tick low", irq_tick, 0);
        // R5 count write does not set the tick flag
        wr(A_CN, 7, 1'b0);
        rd(A_ST, v); chk("R5 write no flag", v, 32'h8);
        // R8 clear coincides with a step: set wins
        wr(A_ST, 32'hA, 1'b1);
        rd(A_ST, v); chk("R8 set wins", v, 32'hA);
        chk("R8 irq_tick", irq_tick, 1);
        wr(A_ST, 32'h2, 1'b0);
        rd(A_ST, v); chk("R7 clear and disable", v, 32'h0);

        // R6 alarm by stepping
        wr(A_ST, 32'h4, 1'b0);
        wr(A_AL, 5, 1'b0);
        wr(A_CN, 3, 1'b0);
        pulse();
        rd(A_ST, v); chk("R6 before match", v, 32'h4);
        pulse();
        rd(A_ST, v); chk("R6 match", v, 32'h5);
        chk("R9 irq_alarm high", irq_alarm, 1);
        pulse();
        rd(A_ST, v); chk("R7 sticky alarm", v, 32'h5);
        wr(A_ST, 32'h5, 1'b0);
        rd(A_ST, v); chk("R7 clear alarm", v, 32'h4);
        chk("R9 irq_alarm low", irq_alarm, 0);
        // R6 alarm by count write
        wr(A_CN, 5, 1'b0);
        rd(A_ST, v); chk("R6 write match", v, 32'h5);
        wr(A_ST, 32'h1, 1'b0);
        // R6 disabled
        wr(A_CN, 4, 1'b0);
        pulse();
        rd(A_CN, v); chk("R6 count at alarm", v, 5);
        rd(A_ST, v); chk("R6 disabled no flag", v, 32'h0);

        // R10 unmapped offsets
        rd(5'h0C, v); chk("R10 read 0x0C", v, 0);
        rd(5'h14, v); chk("R10 read 0x14", v, 0);
        wr(5'h0C, 32'hFFFF_FFFF, 1'b0);
        wr(5'h14, 32'hFFFF_FFFF, 1'b0);
        rd(A_AL, v); chk("R10 alarm kept", v, 5);
        rd(A_CN, v); chk("R10 count kept", v, 5);
        rd(A_TR, v); chk("R10 trim kept", v, 0);
        rd(A_ST, v); chk("R10 status kept", v, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule